// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that follows a linked list of descriptors kept in memory. Software hands it the address of the first descriptor and pulses `start`. The channel reads the eight-word descriptor through a word-wide memory master port. For a host-to-host descriptor it copies the payload one 32-bit word at a time, optionally reversing the byte order of each word. It then writes the descriptor's control word back with the valid bit cleared. It either follows the next pointer or halts, as the descriptor asks.

Completion and failure are reported as one-cycle pulses for a separate interrupt block. The descriptor control word selects, for each descriptor, whether the channel stops afterwards, whether a done pulse is raised, and whether bytes are swapped. When `wait_valid` is high, an invalid descriptor is polled until it turns valid, instead of halting the channel.

The memory port follows a request/acknowledge rule. While `mem_req` is high and `mem_ack` is low, the channel holds `mem_addr`, `mem_we` and `mem_wdata` steady. This is how the memory exerts back-pressure. The cycle in which `mem_ack` is high completes the access. In that cycle `mem_rdata` and `mem_err` are valid. An abort is the one case that may withdraw a pending request.

Top module: `dma_chain_chan`

## Requirements
- R1: After reset `busy`, `mem_req`, `done_evt` and `err_evt` are all 0.
- R2: A `start` pulse while idle raises `busy` and reads the eight descriptor words at byte addresses base+0, +4, ... +28, in that order. The word order is control, length, source low, destination low, next pointer low, source high, destination high, next pointer high. `start` is ignored while busy.
- R3: For transfer type 0 (control bits 2:1 = 0), the channel reads ceil(length/4) words from source-low + 4k and writes them to destination-low + 4k. A length of 0 moves nothing.
- R4: With control bit 20 set, each copied word has its four bytes reversed. With it clear, words pass unchanged.
- R5: After the copy, the control word with bit 0 cleared is written to the descriptor's base address. Exactly ceil(length/4)+1 writes are made per descriptor.
- R6: With control bit 16 clear, the next descriptor is fetched from the next-pointer-low word. With it set, the channel halts and `busy` falls until the next `start`.
- R7: With control bit 17 set, `done_evt` pulses for one cycle after the write-back, and `done_eop` shows control bit 3. With bit 17 clear, no done pulse is raised.
- R8: A descriptor with control bit 0 clear and `wait_valid` low halts the channel with no writes and no events.
- R9: With `wait_valid` high, a descriptor whose control bit 0 is clear is re-read until bit 0 is set. `busy` stays high meanwhile, and processing then continues normally.
- R10: Transfer type 1, 2 or 3 pulses `err_evt`, drops `busy` and makes no writes.
- R11: An acknowledge with `mem_err` set pulses `err_evt` in the next cycle and drops `busy`. No further request follows.
- R12: An `abort` pulse while busy makes `busy` and `mem_req` 0 and `err_evt` 1 in the next cycle.
- R13: Once raised, `mem_req` stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until `mem_ack`, unless an abort intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Enable/restart pulse; latches `desc_addr` |
| desc_addr | input | ADDR_W | Byte address of the first descriptor |
| wait_valid | input | 1 | Poll invalid descriptors instead of halting |
| abort | input | 1 | Abort pulse |
| busy | output | 1 | Channel enabled and working |
| done_evt | output | 1 | One-cycle descriptor-done pulse |
| done_eop | output | 1 | End-of-packet flag of the last done descriptor |
| err_evt | output | 1 | One-cycle error pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Error response, valid with `mem_ack` |

## Verification
The bench builds the channel with ADDR_W=16 and LEN_W=8. This lets a 4 KiB model memory hold descriptors, sources and destinations, and lets lengths up to 255 bytes reach a 64-word copy. Each run is short, so many cases fit in one run. The memory model withholds its acknowledge in a repeating pattern. Every access therefore waits under back-pressure, which exercises the hold rule and the acknowledge-cycle data capture. The vector table mixes zero, partial-word, exact-word and multi-word lengths with both swap settings and both end-of-packet values.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int DATA_W   = 32;
  localparam int DESC_WORDS = 8;
  // control word bit positions (descriptor-defined)
  localparam int CB_VALID = 0;
  localparam int CB_XLO   = 1;
  localparam int CB_EOP   = 3;
  localparam int CB_STOP  = 16;
  localparam int CB_IRQ   = 17;
  localparam int CB_SWAP  = 20;
  // descriptor word indices
  localparam int DW_LEN = 1;
  localparam int DW_SRC = 2;
  localparam int DW_DST = 3;
  localparam int DW_NXT = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_HEAD, S_BODY, S_RD, S_WR, S_WB, S_STEP
  } chan_st_t;
endpackage

// File: rtl/dma_byte_swap.sv
module dma_byte_swap #(
  parameter int W = 32
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NB = W / 8;
  logic [W-1:0] rev;
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign rev[8*b +: 8] = din[8*(NB-1-b) +: 8];
  end
  assign dout = en ? rev : din;
endmodule

// File: rtl/dma_beat_cnt.sv
module dma_beat_cnt #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] total,
  input  logic         step,
  output logic [W-1:0] idx,
  output logic         last
);
  logic [W-1:0] remain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      idx    <= '0;
    end else if (load) begin
      remain <= total;
      idx    <= '0;
    end else if (step) begin
      remain <= remain - 1'b1;
      idx    <= idx + 1'b1;
    end
  end
  assign last = (remain == W'(1));
endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic              wait_valid,
  input  logic              abort,
  output logic              busy,
  output logic              done_evt,
  output logic              done_eop,
  output logic              err_evt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_err
);
  localparam int CNT_W = LEN_W - 1;
  localparam int FI_W  = $clog2(DESC_WORDS);

  chan_st_t          st;
  logic [FI_W-1:0]   fidx;
  logic [ADDR_W-1:0] cur_ptr, src_q, dst_q, nxt_q;
  logic [DATA_W-1:0] ctrl_q, data_q, swapped;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W:0]    len_rnd;
  logic [CNT_W-1:0]  nwords, beat_idx;
  logic              beat_last, cnt_load, cnt_step, ok_ack, bad_type;

  assign len_rnd  = {1'b0, len_q} + (LEN_W+1)'(3);
  assign nwords   = len_rnd[LEN_W:2];
  assign ok_ack   = mem_ack && !mem_err && !abort;
  assign bad_type = (ctrl_q[CB_XLO +: 2] != 2'd0);
  assign cnt_load = (st == S_BODY) && ok_ack && (fidx == FI_W'(DESC_WORDS-1)) && !bad_type;
  assign cnt_step = (st == S_WR) && ok_ack;

  dma_beat_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .total(nwords),
    .step(cnt_step), .idx(beat_idx), .last(beat_last)
  );

  dma_byte_swap #(.W(DATA_W)) u_swap (
    .en(ctrl_q[CB_SWAP]), .din(data_q), .dout(swapped)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_ptr;
    mem_wdata = ctrl_q & ~(DATA_W'(1) << CB_VALID);
    case (st)
      S_HEAD: mem_req = 1'b1;
      S_BODY: begin
        mem_req  = 1'b1;
        mem_addr = cur_ptr + ADDR_W'({fidx, 2'b00});
      end
      S_RD: begin
        mem_req  = 1'b1;
        mem_addr = src_q + ADDR_W'({beat_idx, 2'b00});
      end
      S_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dst_q + ADDR_W'({beat_idx, 2'b00});
        mem_wdata = swapped;
      end
      S_WB: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  busy <= 1'b0;  fidx <= '0;
      cur_ptr <= '0; src_q <= '0;   dst_q <= '0;  nxt_q <= '0;
      ctrl_q <= '0;  data_q <= '0;  len_q <= '0;
      done_evt <= 1'b0; done_eop <= 1'b0; err_evt <= 1'b0;
    end else begin
      done_evt <= 1'b0;
      err_evt  <= 1'b0;
      if (busy && abort) begin
        st <= S_IDLE; busy <= 1'b0; err_evt <= 1'b1;
      end else if (mem_req && mem_ack && mem_err) begin
        st <= S_IDLE; busy <= 1'b0; err_evt <= 1'b1;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            cur_ptr <= desc_addr; busy <= 1'b1; st <= S_HEAD;
          end
          S_HEAD: if (mem_ack) begin
            ctrl_q <= mem_rdata;
            if (mem_rdata[CB_VALID]) begin
              fidx <= FI_W'(1); st <= S_BODY;
            end else if (!wait_valid) begin
              st <= S_IDLE; busy <= 1'b0;
            end
          end
          S_BODY: if (mem_ack) begin
            case (int'(fidx))
              DW_LEN: len_q <= mem_rdata[LEN_W-1:0];
              DW_SRC: src_q <= mem_rdata[ADDR_W-1:0];
              DW_DST: dst_q <= mem_rdata[ADDR_W-1:0];
              DW_NXT: nxt_q <= mem_rdata[ADDR_W-1:0];
              default: ;
            endcase
            fidx <= fidx + 1'b1;
            if (fidx == FI_W'(DESC_WORDS-1)) begin
              if (bad_type) begin
                st <= S_IDLE; busy <= 1'b0; err_evt <= 1'b1;
              end else begin
                st <= (nwords == '0) ? S_WB : S_RD;
              end
            end
          end
          S_RD: if (mem_ack) begin
            data_q <= mem_rdata; st <= S_WR;
          end
          S_WR: if (mem_ack) st <= beat_last ? S_WB : S_RD;
          S_WB: if (mem_ack) st <= S_STEP;
          S_STEP: begin
            if (ctrl_q[CB_IRQ]) begin
              done_evt <= 1'b1; done_eop <= ctrl_q[CB_EOP];
            end
            if (ctrl_q[CB_STOP]) begin
              st <= S_IDLE; busy <= 1'b0;
            end else begin
              cur_ptr <= nxt_q; st <= S_HEAD;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              abort,
  input logic              busy,
  input logic              done_evt,
  input logic              err_evt,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ack,
  input logic              mem_err
);
  a_r13_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !abort |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  a_r12_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
    abort && busy |=> !busy && !mem_req && err_evt);
  a_r11_mem_err: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err && !abort |=> err_evt && !busy);
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !done_evt);
  a_r7_evt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_evt && err_evt));
endmodule

bind dma_chain_chan dma_chain_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .busy(busy),
  .done_evt(done_evt), .err_evt(err_evt), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err)
);

// File: tb/sim_dma_chain_chan.sv
`timescale 1ns/1ps
module sim_dma_chain_chan;
  localparam int AW = 16;
  localparam int LW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, wait_valid = 1'b0, abort = 1'b0;
  logic [AW-1:0] desc_addr = '0;
  logic busy, done_evt, done_eop, err_evt, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  dma_chain_chan #(.ADDR_W(AW), .LEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .desc_addr(desc_addr),
    .wait_valid(wait_valid), .abort(abort), .busy(busy), .done_evt(done_evt),
    .done_eop(done_eop), .err_evt(err_evt), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .mem_err(mem_err)
  );

  int checks = 0, errors = 0;
  logic [31:0] mem [0:1023];
  logic [AW-1:0] rd_log [0:4095];
  int rd_cnt = 0, wr_cnt = 0, done_cnt = 0, err_cnt = 0, hold_viol = 0;
  logic [AW-1:0] err_addr = 16'hFFFF;
  logic [7:0] cyc = '0;
  logic p_req = 1'b0, p_ack = 1'b0, p_abort = 1'b0, p_we = 1'b0;
  logic [AW-1:0] p_addr = '0;

  // memory model with periodic back-pressure
  always @(posedge clk) begin
    cyc <= cyc + 1'b1;
    if (done_evt) done_cnt <= done_cnt + 1;
    if (err_evt) err_cnt <= err_cnt + 1;
    if (rst_n && p_req && !p_ack && !p_abort && !(mem_req && mem_addr == p_addr && mem_we == p_we))
      hold_viol <= hold_viol + 1;
    p_req <= mem_req; p_ack <= mem_ack; p_abort <= abort; p_we <= mem_we; p_addr <= mem_addr;
    mem_ack <= 1'b0;
    mem_err <= 1'b0;
    if (rst_n && mem_req && !mem_ack && cyc[1:0] != 2'd3) begin
      mem_ack <= 1'b1;
      mem_err <= (mem_addr == err_addr);
      if (mem_we) begin
        if (mem_addr != err_addr) mem[mem_addr[11:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[11:2]];
        if (rd_cnt < 4096) rd_log[rd_cnt] <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  function automatic logic [31:0] srcpat(int i);
    return {8'(i), 8'hA5, 8'(i + 7), 8'h3C};
  endfunction
  function automatic logic [31:0] bswap(logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
  function automatic logic [31:0] sentinel(int i);
    return 32'hDEAD0000 + i;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic init_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    for (int i = 0; i < 128; i++) mem[256 + i] = srcpat(i);
    for (int i = 0; i < 256; i++) mem[512 + i] = sentinel(i);
  endtask

  task automatic put_desc(input int bw, input logic [31:0] c, input int len,
                          input int src, input int dst, input int nxt);
    mem[bw] = c; mem[bw+1] = len; mem[bw+2] = src; mem[bw+3] = dst;
    mem[bw+4] = nxt; mem[bw+5] = 0; mem[bw+6] = 0; mem[bw+7] = 0;
  endtask

  task automatic kick(input int addr);
    @(negedge clk); desc_addr = AW'(addr); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    @(negedge clk); @(negedge clk);
  endtask

  // count mismatches of destination words against expectation
  function automatic int dst_bad(int nw, bit sw, int dw, int sw0);
    int bad = 0;
    for (int w = 0; w < nw + 2; w++) begin
      logic [31:0] e;
      e = (w < nw) ? (sw ? bswap(srcpat(sw0 + w)) : srcpat(sw0 + w)) : sentinel(dw - 512 + w);
      if (mem[dw + w] !== e) bad++;
    end
    return bad;
  endfunction

  localparam int  VLEN  [8] = '{0, 1, 4, 5, 16, 30, 7, 60};
  localparam bit  VSWAP [8] = '{0, 0, 0, 1, 1, 0, 1, 0};
  localparam bit  VEOP  [8] = '{1, 0, 1, 0, 1, 1, 0, 1};

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] c;
    int d0, e0, w0, r0, nw;
    init_mem();
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 req", mem_req, 0);
    chk("R1 done", done_evt, 0); chk("R1 err", err_evt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after release", busy, 0);

    // vector table: R3 R4 R5 R7
    for (int v = 0; v < 8; v++) begin
      init_mem();
      c = 32'h1 | (32'h1 << 17) | (32'h1 << 16) | (32'(VEOP[v]) << 3) | (32'(VSWAP[v]) << 20);
      put_desc(0, c, VLEN[v], 32'h400, 32'h800, 0);
      d0 = done_cnt; w0 = wr_cnt; r0 = rd_cnt;
      nw = (VLEN[v] + 3) / 4;
      kick(0);
      wait_idle();
      if (v == 0) for (int k = 0; k < 8; k++) chk("R2 fetch order", 32'(rd_log[r0 + k]), 32'(4 * k));
      chk("R3 R4 data words", dst_bad(nw, VSWAP[v], 512, 0), 0);
      chk("R5 writeback", mem[0], c & ~32'h1);
      chk("R5 write count", wr_cnt - w0, nw + 1);
      chk("R7 done count", done_cnt - d0, 1);
      chk("R7 eop", done_eop, VEOP[v]);
      chk("R6 halted", busy, 0);
    end

    // chain of two descriptors: R6
    init_mem();
    put_desc(0, 32'h1 | (32'h1 << 17), 8, 32'h400, 32'h800, 32'h40);
    put_desc(16, 32'h1 | (32'h1 << 17) | (32'h1 << 16) | 32'h8, 4, 32'h420, 32'h900, 0);
    d0 = done_cnt;
    kick(0);
    wait_idle();
    chk("R6 two done", done_cnt - d0, 2);
    chk("R6 first wb", mem[0], 32'h1 << 17);
    chk("R6 second wb", mem[16], (32'h1 << 17) | (32'h1 << 16) | 32'h8);
    chk("R6 first data", dst_bad(2, 0, 512, 0), 0);
    chk("R6 second data", mem[576], srcpat(8));
    chk("R6 eop of second", done_eop, 1);

    // no interrupt request: R7
    init_mem();
    put_desc(0, 32'h1 | (32'h1 << 16), 4, 32'h400, 32'h800, 0);
    d0 = done_cnt;
    kick(0); wait_idle();
    chk("R7 no done without bit17", done_cnt - d0, 0);
    chk("R7 copy still done", mem[512], srcpat(0));

    // start while busy is ignored: R2
    init_mem();
    put_desc(0, 32'h1 | (32'h1 << 16) | (32'h1 << 17), 60, 32'h400, 32'h800, 0);
    put_desc(32, 32'h1 | (32'h1 << 16) | (32'h1 << 17), 4, 32'h400, 32'hA00, 0);
    d0 = done_cnt;
    kick(0);
    repeat (10) @(negedge clk);
    kick(32'h80);
    wait_idle();
    chk("R2 restart ignored done", done_cnt - d0, 1);
    chk("R2 restart ignored dst", mem[640], sentinel(128));

    // invalid, no wait: R8
    init_mem();
    put_desc(0, 32'h0, 8, 32'h400, 32'h800, 0);
    d0 = done_cnt; e0 = err_cnt; w0 = wr_cnt;
    kick(0); wait_idle();
    chk("R8 halted", busy, 0);
    chk("R8 no writes", wr_cnt - w0, 0);
    chk("R8 no events", (done_cnt - d0) + (err_cnt - e0), 0);

    // invalid with wait: R9
    init_mem();
    put_desc(0, 32'h0, 8, 32'h400, 32'h800, 0);
    wait_valid = 1'b1;
    d0 = done_cnt; r0 = rd_cnt;
    kick(0);
    repeat (40) @(negedge clk);
    chk("R9 still busy", busy, 1);
    chk("R9 polling rereads", 32'(rd_cnt - r0 > 3), 1);
    mem[0] = 32'h1 | (32'h1 << 16) | (32'h1 << 17);
    wait_idle();
    wait_valid = 1'b0;
    chk("R9 done after valid", done_cnt - d0, 1);
    chk("R9 data", dst_bad(2, 0, 512, 0), 0);

    // unsupported transfer type: R10
    for (int t = 1; t < 4; t++) begin
      init_mem();
      put_desc(0, 32'h1 | (32'(t) << 1) | (32'h1 << 16) | (32'h1 << 17), 8, 32'h400, 32'h800, 0);
      e0 = err_cnt; w0 = wr_cnt; d0 = done_cnt;
      kick(0); wait_idle();
      chk("R10 error event", err_cnt - e0, 1);
      chk("R10 no writes", wr_cnt - w0, 0);
      chk("R10 no done", done_cnt - d0, 0);
      chk("R10 halted", busy, 0);
    end

    // memory error response: R11
    init_mem();
    put_desc(0, 32'h1 | (32'h1 << 16) | (32'h1 << 17), 16, 32'h400, 32'h800, 0);
    err_addr = 16'h408;
    e0 = err_cnt; w0 = wr_cnt;
    kick(0); wait_idle();
    err_addr = 16'hFFFF;
    chk("R11 error event", err_cnt - e0, 1);
    chk("R11 halted", busy, 0);
    chk("R11 writes before fault", wr_cnt - w0, 2);
    chk("R11 no writeback", mem[0], 32'h1 | (32'h1 << 16) | (32'h1 << 17));

    // abort: R12
    init_mem();
    put_desc(0, 32'h1 | (32'h1 << 16) | (32'h1 << 17), 60, 32'h400, 32'h800, 0);
    d0 = done_cnt;
    kick(0);
    repeat (30) @(negedge clk);
    chk("R12 busy before abort", busy, 1);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk("R12 busy dropped", busy, 0);
    chk("R12 req dropped", mem_req, 0);
    chk("R12 err pulse", err_evt, 1);
    repeat (3) @(negedge clk);
    chk("R12 no done", done_cnt - d0, 0);

    chk("R13 request held until ack", hold_viol, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule